// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block is a bus-master engine that carries out one configuration transfer at a time. Each transfer is described by a 16-byte descriptor in system memory. The host starts a transfer by writing the descriptor's physical address into a 64-bit trigger register. It can do this with a single 64-bit write. It can also use two 32-bit writes: the upper half goes first at offset 0, and the lower half at offset 4 starts the operation. Reading the trigger register always returns a fixed identification constant.

The engine fetches the descriptor byte by byte. It can select a configuration item, and then do one of three things to that item at its current offset: copy bytes from it into RAM, copy bytes from RAM into it, or move the offset forward. When the work is done, the engine writes the descriptor's control word back in place, as all zeros on success or with the error bit set on failure. The current key and offset are held in the engine and shown to the item store on a shared port. The store answers with the item's size, its read-only flag and the byte at the current offset. The host may also load the key directly through a selector input.

Top module: `cfg_dma_engine`

## Requirements
- R1: A 64-bit trigger write (`trg_full`=1) while idle starts an operation using the descriptor at `trg_wdata`, and `busy` rises on the next cycle.
- R2: With 32-bit writes (`trg_full`=0), a write with `trg_lo`=0 only stores the upper address half. A later write with `trg_lo`=1 starts the operation at {stored upper half, `trg_wdata[31:0]`}.
- R3: The descriptor is read big-endian in this order: control word at bytes 0..3, length at bytes 4..7, RAM address at bytes 8..15.
- R4: Control bit 3 selects key = control[31:16] and sets the offset to 0 before any transfer. A `sel_wr` pulse while idle does the same with `sel_key`. Without a select, the offset carries over from the previous operation.
- R5: A read (control bit 1) writes `length` bytes to RAM starting at `address`. Bytes at offsets inside the item are item data; bytes at offsets at or past the item size are written as 0x00. The offset advances only while it is inside the item.
- R6: A write (bit 4 set, bit 1 clear) copies `length` bytes from RAM into the item at consecutive offsets, and the offset advances by `length`.
- R7: A write whose end (offset + length) is beyond the item size, or whose target item is read-only, changes no item byte and reports an error.
- R8: A skip (bit 2 set, bits 1 and 4 clear) advances the offset by `length` and moves no data.
- R9: On completion the four control bytes are written back as 00 00 00 00 on success, or 00 00 00 01 on error.
- R10: While `busy` is high, trigger writes and selector writes are ignored.
- R11: `reg_rdata` always reads 0x51454d5520434647.
- R12: Read has priority over write, and write over skip. A control word with none of bits 1, 2 or 4 set completes as a success with no data moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trg_wr | input | 1 | Trigger register write strobe |
| trg_full | input | 1 | 1: 64-bit write, 0: 32-bit write |
| trg_lo | input | 1 | For 32-bit writes: 0 upper half (offset 0), 1 lower half (offset 4) |
| trg_wdata | input | 64 | Trigger write data |
| reg_rdata | output | 64 | Trigger register read value |
| sel_wr | input | 1 | Direct selector write strobe |
| sel_key | input | 16 | Key for direct selector write |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: memory byte write, 0: byte read |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| itm_key | output | 16 | Current item key |
| itm_off | output | 32 | Current item offset |
| itm_size | input | 32 | Size of the current item in bytes |
| itm_ro | input | 1 | Current item is read-only |
| itm_rdata | input | 8 | Item byte at the current offset |
| itm_we | output | 1 | Item byte write strobe |
| itm_wdata | output | 8 | Item write byte |

## Verification
If the stored key or offset is wrong, the next read or write shows it at once. The bytes that reach RAM or the item come from the wrong place, and the offset is visible on `itm_off` as soon as `busy` falls. A wrong bounds decision shows within the same operation: either item bytes change when they should not, or the written-back control word differs from 00 00 00 01. A misparsed descriptor moves data to the wrong RAM bytes or writes back at the wrong place. Every such fault appears in memory before the next trigger can be accepted.

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trg_wr,
  input  logic        trg_full,
  input  logic        trg_lo,
  input  logic [63:0] trg_wdata,
  output logic [63:0] reg_rdata,
  input  logic        sel_wr,
  input  logic [15:0] sel_key,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_ack,
  output logic [15:0] itm_key,
  output logic [31:0] itm_off,
  input  logic [31:0] itm_size,
  input  logic        itm_ro,
  input  logic [7:0]  itm_rdata,
  output logic        itm_we,
  output logic [7:0]  itm_wdata
);
  localparam logic [63:0] ID_WORD = 64'h5145_4d55_2043_4647;
  localparam int DSC_BYTES = 16;
  localparam int CTL_BYTES = 4;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_SEL, S_DEC, S_RD, S_WR, S_STAT} st_t;
  st_t st;

  logic [31:0]  hi_half;
  logic [63:0]  dsc_base;
  logic [127:0] dsc;
  logic [31:0]  cnt;
  logic         err;

  wire [31:0] ctl = dsc[127:96];
  wire [31:0] len = dsc[95:64];
  wire [63:0] ram = dsc[63:0];
  wire unused_ok = &{1'b0, ctl[15:5], ctl[0]};

  wire        go      = trg_wr && !busy && (trg_full || trg_lo);
  wire [63:0] go_addr = trg_full ? trg_wdata : {hi_half, trg_wdata[31:0]};
  wire        in_item = itm_off < itm_size;
  wire        last    = cnt == len - 32'd1;
  wire [32:0] wr_end  = {1'b0, itm_off} + {1'b0, len};
  wire        reject  = itm_ro || (wr_end > {1'b0, itm_size});

  assign reg_rdata = ID_WORD;
  assign busy      = st != S_IDLE;
  assign mem_req   = st == S_FETCH || st == S_RD || st == S_WR || st == S_STAT;
  assign mem_we    = st == S_RD || st == S_STAT;
  assign mem_addr  = ((st == S_RD || st == S_WR) ? ram : dsc_base) + {32'b0, cnt};
  assign mem_wdata = (st == S_RD) ? (in_item ? itm_rdata : 8'h00)
                                  : {7'b0, err && cnt == CTL_BYTES - 1};
  assign itm_we    = st == S_WR && mem_ack;
  assign itm_wdata = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      hi_half <= '0;
      dsc_base <= '0;
      dsc <= '0;
      cnt <= '0;
      err <= 1'b0;
      itm_key <= '0;
      itm_off <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (sel_wr) begin
            itm_key <= sel_key;
            itm_off <= '0;
          end
          if (trg_wr && !trg_full && !trg_lo) hi_half <= trg_wdata[31:0];
          if (go) begin
            dsc_base <= go_addr;
            cnt <= '0;
            err <= 1'b0;
            st <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack) begin
          dsc <= {dsc[119:0], mem_rdata};
          if (cnt == DSC_BYTES - 1) begin
            cnt <= '0;
            st <= S_SEL;
          end else cnt <= cnt + 32'd1;
        end
        S_SEL: begin
          if (ctl[3]) begin
            itm_key <= ctl[31:16];
            itm_off <= '0;
          end
          st <= S_DEC;
        end
        S_DEC: begin
          if (ctl[1]) st <= (len == 0) ? S_STAT : S_RD;
          else if (ctl[4]) begin
            if (reject) begin
              err <= 1'b1;
              st <= S_STAT;
            end else st <= (len == 0) ? S_STAT : S_WR;
          end else begin
            if (ctl[2]) itm_off <= itm_off + len;
            st <= S_STAT;
          end
        end
        S_RD, S_WR: if (mem_ack) begin
          if (st == S_WR || in_item) itm_off <= itm_off + 32'd1;
          if (last) begin
            cnt <= '0;
            st <= S_STAT;
          end else cnt <= cnt + 32'd1;
        end
        S_STAT: if (mem_ack) begin
          if (cnt == CTL_BYTES - 1) begin
            cnt <= '0;
            st <= S_IDLE;
          end else cnt <= cnt + 32'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_BUSY_AFTER_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy && mem_addr == $past(go_addr)); // R1
  AST_ITEM_WR_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    itm_we |-> in_item && !itm_ro); // R7
  AST_OFF_STEP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    itm_we |=> itm_off == $past(itm_off) + 32'd1); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !itm_we); // R10
  AST_TRIG_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && trg_wr |=> $stable(dsc_base)); // R10
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R3
endmodule

// File: tb/test_cfg_dma_engine.sv
module test_cfg_dma_engine;
  logic clk = 0, rst_n = 0;
  logic trg_wr = 0, trg_full = 0, trg_lo = 0;
  logic [63:0] trg_wdata = '0, reg_rdata;
  logic sel_wr = 0;
  logic [15:0] sel_key = '0;
  logic busy, mem_req, mem_we, mem_ack, itm_ro, itm_we;
  logic [63:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, itm_rdata, itm_wdata;
  logic [15:0] itm_key;
  logic [31:0] itm_off, itm_size;
  int errors = 0, checks = 0;
  logic [7:0] mem [256];
  logic [7:0] item [4][16];
  logic [7:0] init [4][16];

  always #4 clk = ~clk;

  cfg_dma_engine i_cfg_dma_engine (.*);

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[7:0]];
  assign itm_size  = (itm_key[1:0] == 2'd3) ? 32'd6 : 32'd16;
  assign itm_ro    = itm_key[1:0] == 2'd2;
  assign itm_rdata = (itm_off < 16) ? item[itm_key[1:0]][itm_off[3:0]] : 8'h00;

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (itm_we) item[itm_key[1:0]][itm_off[3:0]] <= itm_wdata;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int b, input logic [31:0] c, input logic [31:0] l, input logic [63:0] a);
    logic [127:0] d = {c, l, a};
    for (int i = 0; i < 16; i++) mem[b + i] = d[127 - 8*i -: 8];
  endtask

  task automatic trig64(input logic [63:0] a);
    @(negedge clk);
    trg_wr = 1; trg_full = 1; trg_wdata = a;
    @(negedge clk);
    trg_wr = 0; trg_full = 0;
  endtask

  task automatic trig32(input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    trg_wr = 1; trg_full = 0; trg_lo = 0; trg_wdata = {32'hdead_beef, hi};
    @(negedge clk);
    trg_lo = 1; trg_wdata = {32'hdead_beef, lo};
    @(negedge clk);
    trg_wr = 0; trg_lo = 0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    if (busy) chk({req, " timeout"}, 1, 0);
  endtask

  task automatic chk_status(input string req, input int b, input logic [31:0] exp);
    chk(req, {mem[b], mem[b+1], mem[b+2], mem[b+3]}, exp);
  endtask

  task automatic t_reset;
    chk("R11 id", reg_rdata, 64'h51454d5520434647);
    chk("R10 busy at reset", busy, 0);
    chk("R4 key/off at reset", {itm_key, itm_off}, 0);
  endtask

  task automatic t_wide_read;
    for (int i = 0; i < 8; i++) mem[8'h80 + i] = 8'hEE;
    put_desc(8'h40, 32'h0001_000A, 8, 64'h80);
    trig64(64'h40);
    chk("R1 busy after trigger", busy, 1);
    wait_idle("R1");
    for (int i = 0; i < 8; i++) chk("R5 R3 read data", mem[8'h80 + i], init[1][i]);
    chk_status("R9 success", 8'h40, 0);
    chk("R4 key selected", itm_key, 1);
    chk("R5 offset advance", itm_off, 8);
  endtask

  task automatic t_split_read;
    put_desc(8'h40, 32'h0000_0002, 4, 64'h90);
    trig32(0, 32'h40);
    wait_idle("R2");
    for (int i = 0; i < 4; i++) chk("R2 R4 continued read", mem[8'h90 + i], init[1][8 + i]);
    chk("R2 offset", itm_off, 12);
  endtask

  task automatic t_read_past_end;
    for (int i = 0; i < 10; i++) mem[8'h80 + i] = 8'hEE;
    put_desc(8'h40, 32'h0003_000A, 10, 64'h80);
    trig64(64'h40);
    wait_idle("R5");
    for (int i = 0; i < 10; i++)
      chk("R5 zero fill", mem[8'h80 + i], (i < 6) ? init[3][i] : 8'h00);
    chk("R5 offset capped", itm_off, 6);
  endtask

  task automatic t_write_ok;
    for (int i = 0; i < 4; i++) mem[8'hA0 + i] = 8'hC0 + i;
    put_desc(8'h40, 32'h0000_0018, 4, 64'hA0);
    trig64(64'h40);
    wait_idle("R6");
    for (int i = 0; i < 5; i++)
      chk("R6 item written", item[0][i], (i < 4) ? 8'hC0 + i : init[0][i]);
    chk_status("R6 R9 status", 8'h40, 0);
    chk("R6 offset", itm_off, 4);
  endtask

  task automatic t_write_reject(input logic [15:0] k, input logic [31:0] l);
    put_desc(8'h40, {k, 16'h0018}, l, 64'hA0);
    trig64(64'h40);
    wait_idle("R7");
    for (int i = 0; i < 16; i++) chk("R7 item unchanged", item[k[1:0]][i], init[k[1:0]][i]);
    chk_status("R7 R9 error status", 8'h40, 32'h1);
    chk("R7 offset kept", itm_off, 0);
  endtask

  task automatic t_skip;
    put_desc(8'h40, 32'h0001_000C, 5, 64'hB0);
    mem[8'hB0] = 8'h5A;
    trig64(64'h40);
    wait_idle("R8");
    chk("R8 offset skipped", itm_off, 5);
    chk("R8 no data moved", mem[8'hB0], 8'h5A);
    chk_status("R8 status", 8'h40, 0);
  endtask

  task automatic t_priority;
    put_desc(8'h40, 32'h0000_0012, 2, 64'h88);
    trig64(64'h40);
    wait_idle("R12");
    chk("R12 read wins data", {mem[8'h88], mem[8'h89]}, {init[1][5], init[1][6]});
    chk("R12 item untouched", item[1][5], init[1][5]);
    put_desc(8'h40, 32'h0000_0000, 3, 64'h88);
    mem[8'h88] = 8'h77;
    trig64(64'h40);
    wait_idle("R12");
    chk("R12 no-op offset", itm_off, 7);
    chk("R12 no-op ram", mem[8'h88], 8'h77);
    chk_status("R12 no-op status", 8'h40, 0);
  endtask

  task automatic t_busy_ignore;
    put_desc(8'h00, 32'h0001_000A, 40, 64'hB0);
    put_desc(8'h20, 32'h0002_0004, 3, 64'h0);
    trig64(64'h00);
    trig64(64'h20);
    @(negedge clk);
    sel_wr = 1; sel_key = 16'h0003;
    @(negedge clk);
    sel_wr = 0;
    wait_idle("R10");
    chk_status("R10 second desc untouched", 8'h20, 32'h0002_0004);
    chk_status("R10 first op status", 8'h00, 0);
    chk("R10 selector ignored", itm_key, 1);
    chk("R5 offset saturates", itm_off, 16);
    chk("R5 tail zero", mem[8'hD7], 8'h00);
    @(negedge clk);
    sel_wr = 1; sel_key = 16'h0002;
    @(negedge clk);
    sel_wr = 0;
    chk("R4 direct select", {itm_key, itm_off}, {16'h0002, 32'h0});
  endtask

  initial begin
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 16; i++) begin
        init[k][i] = 8'h30 + 8'(k * 16 + i);
        item[k][i] = init[k][i];
      end
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_wide_read();
    t_split_read();
    t_read_past_end();
    t_write_ok();
    t_write_reject(16'h0003, 8);
    t_write_reject(16'h0002, 2);
    t_skip();
    t_priority();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule